// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two ports share in order to reserve common resources. The latches sit outside the main memory space. Each port reaches them through its own semaphore select, address, write and read strobes, and data lines. To ask for a token, a port writes 0 with bit 0 of its data. To give a token up, or to withdraw a request it has not yet been granted, the port writes 1. The port then reads the latch back: 0 means that it holds the token, and 1 means that it does not.

A request from a port that does not hold the token is not lost. The latch keeps it. When the holder releases, the token passes straight to the waiting port in the same cycle, so the latch never becomes free for a third party in between. Read results are registered and held, so a later write from the opposite port cannot disturb a value that has already been returned. A semaphore access counts only while that port's memory enable is inactive.

Top module: `token_bank`

## Requirements
- R1: The latch is chosen by the low three address bits; upper address bits have no effect.
- R2: A write uses only data bit 0: bit 0 equal to 0 is a request, bit 0 equal to 1 is a release or a withdrawal, and all other bits are ignored.
- R3: A free latch reads 1 on both ports. A latch held by one port reads 0 on that port and 1 on the other port, and never reads 0 on both ports.
- R4: A latch that one port holds is changed only by that port. A request written by the other port leaves both read values unchanged.
- R5: When the holder writes 1 while the other port has a request waiting, the token passes to the waiting port. With no request waiting, the latch becomes free.
- R6: A waiting port that writes 1 before the holder releases withdraws its request, and a later release then frees the latch.
- R7: A read returns the latch value on every data bit, all ones or all zeros, one cycle after the read strobe. The output then holds that value until the next valid read on the same port.
- R8: When both ports request the same free latch in the same cycle, the left port obtains it and the right port's request stays waiting.
- R9: After reset every latch is free and both read outputs are all ones.
- R10: A port's read or write has no effect while that port's memory enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; blocks semaphore access when high |
| l_addr | input | ADDR_W | Left address; bits 2:0 pick the latch |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left registered read value |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; blocks semaphore access when high |
| r_addr | input | ADDR_W | Right address; bits 2:0 pick the latch |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right registered read value |

## Verification
A write takes effect at the clock edge that samples it. A read issued in the next cycle therefore sees the new ownership. The read result appears on the data output one edge after the read strobe. The bench drives every strobe for exactly one cycle, starting just after a falling edge, and samples the read output at the following falling edge. At that point the registered value has settled. Simultaneous left and right operations are presented in the same cycle to test the priority rule and the release-to-waiter handoff.

// File: rtl/token_bank.sv
module token_bank #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int SEM_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int N = 1 << SEM_AW;

  logic              l_ok, r_ok;
  logic [SEM_AW-1:0] l_idx, r_idx;
  logic [N-1:0]      own_l, own_r, req_l, req_r;
  logic [N-1:0]      own_l_n, own_r_n, req_l_n, req_r_n;

  assign l_ok  = l_sel & ~l_mem_en;
  assign r_ok  = r_sel & ~r_mem_en;
  assign l_idx = l_addr[SEM_AW-1:0];
  assign r_idx = r_addr[SEM_AW-1:0];

  for (genvar i = 0; i < N; i++) begin : g_sem
    logic lw, rw, l_set, l_clr, r_set, r_clr;
    assign lw    = l_ok & l_wr & (l_idx == SEM_AW'(i));
    assign rw    = r_ok & r_wr & (r_idx == SEM_AW'(i));
    assign l_set = lw & ~l_wdata[0];
    assign l_clr = lw &  l_wdata[0];
    assign r_set = rw & ~r_wdata[0];
    assign r_clr = rw &  r_wdata[0];

    assign req_l_n[i] = l_set | (req_l[i] & ~l_clr);
    assign req_r_n[i] = r_set | (req_r[i] & ~r_clr);

    always_comb begin
      own_l_n[i] = own_l[i];
      own_r_n[i] = own_r[i];
      if (own_l[i]) begin
        if (l_clr) begin
          own_l_n[i] = 1'b0;
          own_r_n[i] = req_r_n[i];
        end
      end else if (own_r[i]) begin
        if (r_clr) begin
          own_r_n[i] = 1'b0;
          own_l_n[i] = req_l_n[i];
        end
      end else begin
        own_l_n[i] = req_l_n[i];
        own_r_n[i] = ~req_l_n[i] & req_r_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_l <= '0;
      own_r <= '0;
      req_l <= '0;
      req_r <= '0;
    end else begin
      own_l <= own_l_n;
      own_r <= own_r_n;
      req_l <= req_l_n;
      req_r <= req_r_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_ok && l_rd) l_rdata <= {DATA_W{~own_l[l_idx]}};
      if (r_ok && r_rd) r_rdata <= {DATA_W{~own_r[r_idx]}};
    end
  end
endmodule

// File: rtl/token_bank_chk.sv
module token_bank_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int N      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sel,
  input logic              l_mem_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_rd,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_sel,
  input logic              r_mem_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_rd,
  input logic [DATA_W-1:0] r_rdata,
  input logic [N-1:0]      own_l,
  input logic [N-1:0]      own_r
);
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  a_r3_not_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && r_sel && l_rd && r_rd && !l_mem_en && !r_mem_en &&
     l_addr[2:0] == r_addr[2:0]) |=> (l_rdata[0] || r_rdata[0]));

  a_r7_l_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(l_rdata) == 0) || ($countones(l_rdata) == DATA_W));

  a_r7_r_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(r_rdata) == 0) || ($countones(r_rdata) == DATA_W));

  a_r7_l_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_sel && l_rd) |=> $stable(l_rdata));

  a_r10_r_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    r_mem_en |=> $stable(r_rdata));
endmodule

bind token_bank token_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_mem_en(l_mem_en), .l_addr(l_addr), .l_rd(l_rd), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_mem_en(r_mem_en), .r_addr(r_addr), .r_rd(r_rd), .r_rdata(r_rdata),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/token_bank_tb.sv
module token_bank_tb;
  localparam int AW = 14;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sel = 0, l_mem_en = 0, l_wr = 0, l_rd = 0;
  logic r_sel = 0, r_mem_en = 0, r_wr = 0, r_rd = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  token_bank #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_wr = 0; l_rd = 0; l_mem_en = 0;
    r_sel = 0; r_wr = 0; r_rd = 0; r_mem_en = 0;
  endtask

  task automatic lw(logic [AW-1:0] a, logic [DW-1:0] d);
    l_sel = 1; l_wr = 1; l_addr = a; l_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d);
    r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic both_w(logic [AW-1:0] la, logic [DW-1:0] ld,
                        logic [AW-1:0] ra, logic [DW-1:0] rd);
    l_sel = 1; l_wr = 1; l_addr = la; l_wdata = ld;
    r_sel = 1; r_wr = 1; r_addr = ra; r_wdata = rd;
    @(negedge clk); idle();
  endtask

  task automatic check_both(string req, logic [AW-1:0] a,
                            logic [DW-1:0] le, logic [DW-1:0] re);
    l_sel = 1; l_rd = 1; l_addr = a;
    r_sel = 1; r_rd = 1; r_addr = a;
    @(negedge clk); idle();
    chk({req, " left"}, l_rdata, le);
    chk({req, " right"}, r_rdata, re);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) check_both("R9 reset free", AW'(i), ONES, ONES);
  endtask

  task automatic t_hold_and_pass();
    lw(14'd2, 16'h0000);
    check_both("R3 left holds", 14'd2, ZERO, ONES);
    rw(14'd2, 16'h0000);
    check_both("R4 right request ignored", 14'd2, ZERO, ONES);
    lw(14'd2, 16'h0001);
    check_both("R5 handoff to right", 14'd2, ONES, ZERO);
    rw(14'd2, 16'h0001);
    check_both("R5 release to free", 14'd2, ONES, ONES);
  endtask

  task automatic t_withdraw();
    rw(14'd4, 16'h0000);
    lw(14'd4, 16'h0000);
    lw(14'd4, 16'h0001);
    check_both("R6 withdraw keeps right", 14'd4, ONES, ZERO);
    rw(14'd4, 16'h0001);
    check_both("R6 release frees", 14'd4, ONES, ONES);
  endtask

  task automatic t_tie();
    both_w(14'd5, 16'h0000, 14'd5, 16'h0000);
    check_both("R8 left wins tie", 14'd5, ZERO, ONES);
    lw(14'd5, 16'h0001);
    check_both("R8 waiting right gets token", 14'd5, ONES, ZERO);
    rw(14'd5, 16'h0001);
    check_both("R8 cleanup free", 14'd5, ONES, ONES);
  endtask

  task automatic t_addr_data();
    lw(14'h3FF9, 16'hFFFE);
    check_both("R1 R2 high addr and bit0 request", 14'd1, ZERO, ONES);
    check_both("R1 neighbour latch untouched", 14'd0, ONES, ONES);
    lw(14'h2001, 16'h0001);
    check_both("R2 bit0 release", 14'd1, ONES, ONES);
  endtask

  task automatic t_read_hold();
    l_sel = 1; l_rd = 1; l_addr = 14'd3;
    @(negedge clk); idle();
    chk("R7 read free", l_rdata, ONES);
    rw(14'd3, 16'h0000);
    @(negedge clk);
    chk("R7 left output held", l_rdata, ONES);
    check_both("R7 right reads zero on all bits", 14'd3, ONES, ZERO);
    rw(14'd3, 16'h0001);
  endtask

  task automatic t_mem_en();
    l_mem_en = 1; l_sel = 1; l_wr = 1; l_addr = 14'd6; l_wdata = '0;
    @(negedge clk); idle();
    check_both("R10 write blocked", 14'd6, ONES, ONES);
    rw(14'd6, 16'h0000);
    check_both("R10 setup right holds", 14'd6, ONES, ZERO);
    r_mem_en = 1; r_sel = 1; r_rd = 1; r_addr = 14'd0;
    @(negedge clk); idle();
    chk("R10 read blocked", r_rdata, ZERO);
    rw(14'd6, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset left output", l_rdata, ONES);
    chk("R9 reset right output", r_rdata, ONES);
    t_reset();
    t_hold_and_pass();
    t_withdraw();
    t_tie();
    t_addr_data();
    t_read_hold();
    t_mem_en();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule